// File: doc/BRIEF.md
# Byte Prefetch Queue with Queue-Status Reporting

This block sits between a 16-bit code bus and an instruction execution unit. It holds up to six instruction bytes. Whenever enough space is free it asks for the next aligned code word, and it stores the two returned bytes in address order. The execution unit sees the oldest byte on a combinational output and takes it with a read strobe. Along with the strobe, the execution unit says whether the byte starts an instruction or prefix, or continues one.

Every queue operation is reported one cycle later on a two-bit status output, together with the byte that was taken. A flush drops everything stored and restarts fetching from a new address. If that address is odd, the even byte of the first word is thrown away. After a byte is taken from a queue that had no room, fetching stays idle for a fixed gap before the next request.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty: rdAvail is 0, qStatus is 00, qByte is 00, fetchReq is 1 and fetchAddr equals RESET_ADDR.
- R2: fetchReq is high only when at least two byte slots are free. fetchAddr is always even. A request stays up until fetchAck, and each accepted word advances fetchAddr by 2.
- R3: An accepted word queues the byte on fetchData[7:0] (even address) before the byte on fetchData[15:8] (odd address). rdData always shows the oldest byte while rdAvail is 1.
- R4: The queue fills to six bytes when its oldest byte sits at an even address, and to at most five when it sits at an odd address.
- R5: If a byte is read in cycle k while fewer than two slots were free, fetchReq stays low in cycles k+1 and k+2 even if room exists. It may rise again in cycle k+3.
- R6: qStatus reports the operation of the previous cycle. The codes are 01 for a byte read with rdFirst=1, 11 for a byte read with rdFirst=0, and 00 for no operation.
- R7: When qStatus is 01 or 11, qByte is the byte that was read. For any other status, qByte is 00.
- R8: flushValid empties the queue and gives qStatus 10 in the next cycle. It sets fetchAddr to flushAddr with bit 0 cleared, and fetchReq is high in the next cycle. A flush overrides a read and a word arrival in the same cycle, and both are discarded.
- R9: After a flush to an odd address, the first accepted word queues only its odd byte, so the oldest byte is the one at flushAddr.
- R10: A read and an accepted word in the same cycle are both applied: one byte leaves the queue and the new bytes join it.
- R11: A read while rdAvail is 0 is ignored. qStatus stays 00 and the queue is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| flushValid | input | 1 | Empty the queue and restart fetching |
| flushAddr | input | ADDR_W | Byte address where the restart begins |
| fetchReq | output | 1 | Code word fetch requested |
| fetchAddr | output | ADDR_W | Even address of the requested word |
| fetchAck | input | 1 | Requested word is on fetchData this cycle |
| fetchData | input | 16 | Fetched word, even byte in the low half |
| rdReq | input | 1 | Execution unit takes the oldest byte |
| rdFirst | input | 1 | Byte taken starts an instruction or prefix |
| rdAvail | output | 1 | At least one byte is stored |
| rdData | output | 8 | Oldest stored byte |
| qStatus | output | 2 | Previous-cycle queue operation code |
| qByte | output | 8 | Byte read in the previous cycle |

## Verification
A byte read and a word arrival can fall in the same cycle. The bench provokes this by asserting rdReq together with an acknowledge to a pending request, after a flush to an odd address. It then judges the outcome with a byte-level model: the next rdData, the rdAvail level and the following reads must show one byte removed and the new bytes appended in address order. A second collision puts a flush on top of a read and an acknowledge. That case must report only the emptied code, and fetching must resume from the flush address.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef enum logic [1:0] {
    QS_IDLE    = 2'b00,
    QS_FIRST   = 2'b01,
    QS_FLUSHED = 2'b10,
    QS_NEXT    = 2'b11
  } qStat_e;

  typedef struct packed {
    logic clear;
    logic push;
    logic pushHighOnly;
    logic pop;
  } qStrobe_t;

endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH = 6,
  parameter int RESTART_GAP = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              rdReq,
  input  logic              rdFirst,
  input  logic              fetchAck,
  output qStrobe_t          strobe,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              rdAvail,
  output logic [1:0]        qStatus
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int GAP_W = $clog2(RESTART_GAP + 1);
  localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  pushN;
  logic [GAP_W-1:0]  holdCnt;
  logic [ADDR_W-1:0] addrQ;
  logic              headOdd;
  logic              dropEven;
  logic              roomNow;
  logic              popFire;
  logic              pushFire;
  qStat_e            statusQ;

  assign roomNow  = count <= ROOM_LIMIT;
  assign fetchReq = roomNow && (holdCnt == '0);
  assign popFire  = rdReq && (count != '0) && !flushValid;
  assign pushFire = fetchAck && fetchReq && !flushValid;
  assign pushN    = pushFire ? (dropEven ? CNT_W'(1) : CNT_W'(2)) : '0;

  always_comb begin
    strobe.clear        = flushValid;
    strobe.push         = pushFire;
    strobe.pushHighOnly = dropEven;
    strobe.pop          = popFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      holdCnt  <= '0;
      addrQ    <= {RESET_ADDR[ADDR_W-1:1], 1'b0};
      headOdd  <= 1'b0;
      dropEven <= 1'b0;
      statusQ  <= QS_IDLE;
    end else if (flushValid) begin
      count    <= '0;
      holdCnt  <= '0;
      addrQ    <= {flushAddr[ADDR_W-1:1], 1'b0};
      headOdd  <= flushAddr[0];
      dropEven <= flushAddr[0];
      statusQ  <= QS_FLUSHED;
    end else begin
      count <= count + pushN - CNT_W'(popFire);
      if (popFire && !roomNow) holdCnt <= GAP_W'(RESTART_GAP);
      else if (holdCnt != '0)  holdCnt <= holdCnt - GAP_W'(1);
      if (popFire) headOdd <= ~headOdd;
      if (pushFire) begin
        addrQ    <= addrQ + ADDR_W'(2);
        dropEven <= 1'b0;
      end
      if (popFire) statusQ <= rdFirst ? QS_FIRST : QS_NEXT;
      else         statusQ <= QS_IDLE;
    end
  end

  assign fetchAddr = addrQ;
  assign rdAvail   = count != '0;
  assign qStatus   = statusQ;

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  a_r4_odd_cap: assert property (@(posedge clk) disable iff (!rstN)
    headOdd |-> count <= CNT_W'(DEPTH - 1));

  a_r5_restart_gap: assert property (@(posedge clk) disable iff (!rstN)
    (popFire && !roomNow && !flushValid) |=> !fetchReq);

  a_r8_flush_status: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> qStatus == QS_FLUSHED);

endmodule

// File: rtl/pq_data.sv
module pq_data
  import pq_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  qStrobe_t   strobe,
  input  logic [15:0] fetchData,
  output logic [7:0] headByte,
  output logic [7:0] qByte
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [7:0]       slot [DEPTH];
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [PTR_W-1:0] tailNext;
  logic [PTR_W-1:0] tailNext2;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign tailNext  = stepPtr(tailPtr);
  assign tailNext2 = stepPtr(tailNext);
  assign headByte  = slot[headPtr];

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.clear) begin
      if (strobe.pushHighOnly) begin
        slot[tailPtr] <= fetchData[15:8];
      end else begin
        slot[tailPtr]  <= fetchData[7:0];
        slot[tailNext] <= fetchData[15:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      headPtr <= '0;
      tailPtr <= '0;
      qByte   <= 8'h00;
    end else begin
      if (strobe.pop) headPtr <= stepPtr(headPtr);
      if (strobe.push) tailPtr <= strobe.pushHighOnly ? tailNext : tailNext2;
      qByte <= strobe.pop ? headByte : 8'h00;
    end
  end

  a_r3_tail_moves_on_push: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.clear) |=> !$stable(tailPtr));

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH = 6,
  parameter int RESTART_GAP = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  input  logic [15:0]       fetchData,
  input  logic              rdReq,
  input  logic              rdFirst,
  output logic              rdAvail,
  output logic [7:0]        rdData,
  output logic [1:0]        qStatus,
  output logic [7:0]        qByte
);

  qStrobe_t strobe;

  pq_ctrl #(
    .ADDR_W(ADDR_W),
    .DEPTH(DEPTH),
    .RESTART_GAP(RESTART_GAP),
    .RESET_ADDR(RESET_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .flushValid(flushValid),
    .flushAddr(flushAddr),
    .rdReq(rdReq),
    .rdFirst(rdFirst),
    .fetchAck(fetchAck),
    .strobe(strobe),
    .fetchReq(fetchReq),
    .fetchAddr(fetchAddr),
    .rdAvail(rdAvail),
    .qStatus(qStatus)
  );

  pq_data #(
    .DEPTH(DEPTH)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .fetchData(fetchData),
    .headByte(rdData),
    .qByte(qByte)
  );

  // R2: an open request is held until it is acknowledged or flushed
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck && !flushValid) |=> fetchReq);

endmodule

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] RST_ADDR = 20'hFFFF0;

  typedef struct packed {
    logic        rd;
    logic        first;
    logic        ack;
    logic        flush;
    logic [19:0] addr;
    logic [1:0]  expSt;
  } step_t;

  localparam int NSTEP = 34;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 0 fill
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 1
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 2 six bytes
    '{1'b1,1'b1,1'b0,1'b0,20'h0,2'b01},     // 3 first byte
    '{1'b1,1'b0,1'b0,1'b0,20'h0,2'b11},     // 4 read from full odd head
    '{1'b0,1'b0,1'b0,1'b0,20'h0,2'b00},     // 5 gap
    '{1'b0,1'b0,1'b0,1'b0,20'h0,2'b00},     // 6 gap
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 7 restart
    '{1'b1,1'b1,1'b0,1'b0,20'h0,2'b01},     // 8
    '{1'b1,1'b0,1'b0,1'b0,20'h0,2'b11},     // 9
    '{1'b1,1'b0,1'b0,1'b0,20'h0,2'b11},     // 10
    '{1'b1,1'b0,1'b1,1'b0,20'h0,2'b11},     // 11
    '{1'b0,1'b0,1'b0,1'b1,20'h00235,2'b10}, // 12 odd flush
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 13 one byte kept
    '{1'b1,1'b1,1'b1,1'b0,20'h0,2'b01},     // 14 read + word together
    '{1'b1,1'b0,1'b0,1'b0,20'h0,2'b11},     // 15
    '{1'b1,1'b0,1'b0,1'b0,20'h0,2'b11},     // 16
    '{1'b1,1'b0,1'b0,1'b0,20'h0,2'b00},     // 17 read while empty
    '{1'b1,1'b1,1'b1,1'b1,20'h00300,2'b10}, // 18 flush beats read and word
    '{1'b0,1'b0,1'b0,1'b0,20'h0,2'b00},     // 19
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 20
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 21
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 22
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 23 full, no request
    '{1'b0,1'b0,1'b0,1'b1,20'h00401,2'b10}, // 24 odd flush
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 25
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 26
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 27 five bytes
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 28 odd-head cap
    '{1'b1,1'b1,1'b0,1'b0,20'h0,2'b01},     // 29
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 30 gap
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 31 gap
    '{1'b0,1'b0,1'b1,1'b0,20'h0,2'b00},     // 32 restart
    '{1'b1,1'b0,1'b0,1'b0,20'h0,2'b11}      // 33
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushValid = 1'b0;
  logic [19:0] flushAddr = '0;
  logic        fetchReq;
  logic [19:0] fetchAddr;
  logic        fetchAck = 1'b0;
  logic [15:0] fetchData = '0;
  logic        rdReq = 1'b0;
  logic        rdFirst = 1'b0;
  logic        rdAvail;
  logic [7:0]  rdData;
  logic [1:0]  qStatus;
  logic [7:0]  qByte;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0]  mq [8];
  int          mCnt = 0;
  logic [19:0] mAddr = RST_ADDR;
  bit          mDrop = 1'b0;
  int          mHold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_queue u_prefetch_queue (
    .clk(clk), .rstN(rstN), .flushValid(flushValid), .flushAddr(flushAddr),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchAck(fetchAck),
    .fetchData(fetchData), .rdReq(rdReq), .rdFirst(rdFirst),
    .rdAvail(rdAvail), .rdData(rdData), .qStatus(qStatus), .qByte(qByte)
  );

  function automatic logic [7:0] memByte(input logic [19:0] a);
    return a[7:0] ^ {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic runStep(input int i);
    step_t s;
    bit expReq;
    bit popped;
    bit roomM;
    logic [7:0] expB;
    s = STEPS[i];
    expReq = (mCnt <= 4) && (mHold == 0);
    rdReq      = s.rd;
    rdFirst    = s.first;
    flushValid = s.flush;
    flushAddr  = s.addr;
    fetchAck   = s.ack && expReq;
    fetchData  = {memByte(mAddr + 20'd1), memByte(mAddr)};
    #1;
    // R2 request rule, R4 capacity, R5 restart gap
    chk((mCnt >= 5) ? "R4" : ((mHold != 0) ? "R5" : "R2"), "fetchReq",
        32'(fetchReq), 32'(expReq));
    if (expReq) chk("R2", "fetchAddr", 32'(fetchAddr), 32'(mAddr));
    chk("R11", "rdAvail", 32'(rdAvail), 32'(mCnt > 0));
    if (mCnt > 0) chk("R3", "rdData", 32'(rdData), 32'(mq[0]));
    expB = 8'h00;
    if (s.flush) begin
      mCnt = 0;
      mAddr = {s.addr[19:1], 1'b0};
      mDrop = s.addr[0];
      mHold = 0;
    end else begin
      roomM = mCnt <= 4;
      popped = s.rd && (mCnt > 0);
      if (popped) begin
        expB = mq[0];
        for (int k = 0; k < 7; k++) mq[k] = mq[k+1];
        mCnt--;
      end
      if (s.ack && expReq) begin
        if (!mDrop) begin
          mq[mCnt] = memByte(mAddr);
          mCnt++;
        end
        mq[mCnt] = memByte(mAddr + 20'd1);
        mCnt++;
        mAddr = mAddr + 20'd2;
        mDrop = 1'b0;
      end
      if (popped && !roomM) mHold = 2;
      else if (mHold > 0)   mHold--;
    end
    @(posedge clk);
    @(negedge clk);
    // R6 status codes, R8 flush code, R11 ignored read
    chk(s.flush ? "R8" : (s.rd ? "R6" : "R11"), "qStatus",
        32'(qStatus), 32'(s.expSt));
    chk("R7", "qByte", 32'(qByte), 32'(expB));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "reset rdAvail", 32'(rdAvail), 32'd0);
    chk("R1", "reset qStatus", 32'(qStatus), 32'd0);
    chk("R1", "reset qByte", 32'(qByte), 32'd0);
    chk("R1", "reset fetchReq", 32'(fetchReq), 32'd1);
    chk("R1", "reset fetchAddr", 32'(fetchAddr), 32'(RST_ADDR));
    for (int i = 0; i < NSTEP; i++) runStep(i);
    // R10: read and word arrival together left one byte net gained
    // R9: odd flush head byte was the byte at 0x00235 (checked in step 14)
    rdReq = 1'b0; fetchAck = 1'b0; flushValid = 1'b0;
    #1;
    chk("R10", "final rdAvail", 32'(rdAvail), 32'(mCnt > 0));
    // R8: flush resumes at the flush address in the following cycle
    flushValid = 1'b1;
    flushAddr = 20'h12345;
    @(posedge clk);
    @(negedge clk);
    flushValid = 1'b0;
    #1;
    chk("R8", "flush fetchReq", 32'(fetchReq), 32'd1);
    chk("R8", "flush fetchAddr", 32'(fetchAddr), 32'h12344);
    chk("R8", "flush rdAvail", 32'(rdAvail), 32'd0);
    // R9: first word after an odd flush yields only the odd byte
    fetchData = {memByte(20'h12345), memByte(20'h12344)};
    fetchAck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fetchAck = 1'b0;
    #1;
    chk("R9", "odd head byte", 32'(rdData), 32'(memByte(20'h12345)));
    chk("R9", "odd next addr", 32'(fetchAddr), 32'h12346);
    rdReq = 1'b1; rdFirst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdReq = 1'b0;
    #1;
    chk("R9", "single byte kept", 32'(rdAvail), 32'd0);
    chk("R7", "odd byte reported", 32'(qByte), 32'(memByte(20'h12345)));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule